// File: doc/BRIEF.md
# Capture Timer Sync/Trigger Controller

This block is the time base behind a pair of input capture channels. Each channel owns a free-running counter that a selected external source can either restart or gate. In synchronous mode, a pulse on the selected source clears the counter while it keeps counting. In triggered mode, the counter sits at zero until the selected source fires. The run flag then goes high and counting begins.

Software programs each channel through a 16-bit control word that it can write and read back. The control word holds a 5-bit source selector, the run flag, the mode bit and the cascade bit. A capture edge copies the channel's counter into a holding register and pulses a valid strobe for one cycle. When both channels carry the cascade bit, they form one counter of twice the width. Channel 0 is the low half and channel 1 the high half, and channel 0's control fields govern the pair.

Top module: `capt_timebase`

## Requirements
- R1: After reset each channel's control word reads 0x000D (selector 13, run flag 0, synchronous mode, no cascade) and no capture strobe is high.
- R2: Control word layout: selector in bits 4:0, run flag in bit 5, mode in bit 7 (1 = triggered, 0 = synchronous), cascade in bit 8. Bits 15:9 and bit 6 always read 0.
- R3: In synchronous mode the counter advances by one every clock and wraps modulo 2^CNT_W.
- R4: In synchronous mode, when the source picked by the selector is high at a clock edge, the counter is 0 after that edge and counts on from there. Other sources have no effect. A register write does not clear the counter.
- R5: In triggered mode with the run flag at 0, the counter is held at 0 and no unselected source changes that.
- R6: In triggered mode, the selected source being high at an edge sets the run flag at that edge, and the counter reads 1 after it. A further trigger while running does not restart the counter.
- R7: A write takes effect at its edge. Writing run = 1 starts the counter (1 after that edge), and writing run = 0 holds it at 0 from that edge. A hardware trigger in the same cycle as a write of run = 0 leaves the flag at 1.
- R8: With the cascade bit set in both channels, channel 1 advances only when channel 0 wraps from all-ones to zero. Channel 0's mode, selector and run flag clear or hold both halves. Channel 1's own selector has no effect.
- R9: A capture input high at an edge latches the counter value from before that edge, including when a sync clear lands in the same edge. The channel's valid strobe is high for exactly the following cycle.
- R10: In cascade, capture input 0 latches both halves in the same edge and raises both strobes. Capture input 1 alone is ignored.
- R11: The read port returns, combinationally, the control word of the channel given by rd_ch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_ch_i | input | 1 | Channel addressed by the write |
| wr_data_i | input | 16 | Control word write data |
| rd_ch_i | input | 1 | Channel addressed by the read |
| rd_data_o | output | 16 | Control word of the read channel |
| src_i | input | 32 | Sync/trigger source pulses, indexed by the selector |
| cap_i | input | 2 | Capture edge per channel |
| cap_vld_o | output | 2 | One-cycle capture valid per channel |
| cap_data_o | output | 2*CNT_W | Captured values, channel 1 in the upper half |

## Verification
The assertions assume that software never makes a channel its own trigger source. They also assume that inputs usable only as triggers are never picked in synchronous mode. The properties on counting and carry are qualified on cycles without a register write, because a write may change the mode in that cycle. The stimulus selects sources that are plain pulse inputs and uses each one in a single role. It changes the mode only through writes that the reference model mirrors. The bench runs the counter at 8 bits so that free-running wraps and cascade carries are swept in full across consecutive captures.

// File: rtl/capt_timebase_pkg.sv
package capt_timebase_pkg;
  localparam int unsigned CTL_W    = 16;
  localparam int unsigned SEL_W    = 5;
  localparam int unsigned NUM_SRC  = 1 << SEL_W;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned RUN_BIT  = 5;
  localparam int unsigned RSVD_BIT = 6;
  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned CASC_BIT = 8;
  localparam logic [SEL_W-1:0] SEL_RST = 5'b01101;

  typedef struct packed {
    logic             casc;
    logic             mode;   // 1: triggered, 0: synchronous
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  localparam ctl_t CTL_RST = '{casc: 1'b0, mode: 1'b0, run: 1'b0, sel: SEL_RST};

  function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[SEL_W-1:0] = c.sel;
    w[RUN_BIT]   = c.run;
    w[MODE_BIT]  = c.mode;
    w[CASC_BIT]  = c.casc;
    return w;
  endfunction

  function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.sel  = w[SEL_W-1:0];
    c.run  = w[RUN_BIT];
    c.mode = w[MODE_BIT];
    c.casc = w[CASC_BIT];
    return c;
  endfunction
endpackage

// File: rtl/capt_timebase_ctl.sv
module capt_timebase_ctl
  import capt_timebase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             hw_set_i,
  output ctl_t             ctl_q_o,
  output logic             hold_o
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) ctl_d = ctl_unpack(wdata_i);
    // hardware set beats a software clear in the same cycle
    if (hw_set_i) ctl_d.run = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST;
    else         ctl_q <= ctl_d;
  end

  // hold follows the next state so start/stop act at the same edge
  assign hold_o  = ctl_d.mode & ~ctl_d.run;
  assign ctl_q_o = ctl_q;
endmodule

// File: rtl/capt_timebase_cnt.sv
module capt_timebase_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || hold_i) cnt_q <= '0;
    else if (inc_i)           cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/capt_timebase_cap.sv
module capt_timebase_cap #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] data_o,
  output logic             vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) data_o <= val_i;
    end
  end
endmodule

// File: rtl/capt_timebase.sv
module capt_timebase
  import capt_timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_ch_i,
  input  logic [CTL_W-1:0]        wr_data_i,
  input  logic                    rd_ch_i,
  output logic [CTL_W-1:0]        rd_data_o,
  input  logic [NUM_SRC-1:0]      src_i,
  input  logic [NUM_CH-1:0]       cap_i,
  output logic [NUM_CH-1:0]       cap_vld_o,
  output logic [NUM_CH*CNT_W-1:0] cap_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctl_t              ctl_q [NUM_CH];
  logic [NUM_CH-1:0] sel_hit, hw_set, own_hold, own_clr, cap_en;
  logic [CNT_W-1:0]  cnt_w [NUM_CH];
  logic [CNT_W-1:0]  cnt_lo, cnt_hi;
  logic              casc;
  logic              lo_clr, lo_hold, lo_wrap;
  logic              hi_clr, hi_hold, hi_inc;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sel_hit[c] = src_i[ctl_q[c].sel];
    assign hw_set[c]  = ctl_q[c].mode & sel_hit[c];
    assign own_clr[c] = ~ctl_q[c].mode & sel_hit[c];

    capt_timebase_ctl u_ctl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i && (wr_ch_i == 1'(c))),
      .wdata_i  (wr_data_i),
      .hw_set_i (hw_set[c]),
      .ctl_q_o  (ctl_q[c]),
      .hold_o   (own_hold[c])
    );

    capt_timebase_cap #(.CNT_W(CNT_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cap_en[c]),
      .val_i  (cnt_w[c]),
      .data_o (cap_data_o[c*CNT_W +: CNT_W]),
      .vld_o  (cap_vld_o[c])
    );
  end

  assign casc = ctl_q[0].casc & ctl_q[1].casc;

  // low half always runs on its own controls
  assign lo_clr  = own_clr[0];
  assign lo_hold = own_hold[0];
  assign lo_wrap = ~lo_clr & ~lo_hold & (cnt_lo == CNT_MAX);

  // high half follows the low channel when cascaded
  assign hi_clr  = casc ? lo_clr  : own_clr[1];
  assign hi_hold = casc ? lo_hold : own_hold[1];
  assign hi_inc  = casc ? lo_wrap : 1'b1;

  assign cap_en[0] = cap_i[0];
  assign cap_en[1] = casc ? cap_i[0] : cap_i[1];

  capt_timebase_cnt #(.CNT_W(CNT_W)) u_cnt_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (lo_clr),
    .hold_i (lo_hold),
    .inc_i  (1'b1),
    .cnt_o  (cnt_lo)
  );

  capt_timebase_cnt #(.CNT_W(CNT_W)) u_cnt_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hi_clr),
    .hold_i (hi_hold),
    .inc_i  (hi_inc),
    .cnt_o  (cnt_hi)
  );

  assign cnt_w[0] = cnt_lo;
  assign cnt_w[1] = cnt_hi;

  assign rd_data_o = ctl_pack(ctl_q[rd_ch_i]);
endmodule

// File: rtl/capt_timebase_chk.sv
module capt_timebase_chk
  import capt_timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [NUM_SRC-1:0]      src_i,
  input logic [NUM_CH-1:0]       cap_i,
  input logic [NUM_CH-1:0]       cap_vld_o,
  input logic [NUM_CH*CNT_W-1:0] cap_data_o,
  input logic [CTL_W-1:0]        rd_data_o,
  input ctl_t                    ctl0_i,
  input logic                    casc_i,
  input logic [CNT_W-1:0]        cnt0_i,
  input logic [CNT_W-1:0]        cnt1_i
);
  logic             sel0_hit, lo_max;
  logic [CNT_W-1:0] inc0, inc1;

  assign sel0_hit = src_i[ctl0_i.sel];
  assign lo_max   = (cnt0_i == {CNT_W{1'b1}});
  assign inc0     = cnt0_i + 1'b1;
  assign inc1     = cnt1_i + 1'b1;

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[CTL_W-1:CASC_BIT+1] == '0) && !rd_data_o[RSVD_BIT]);

  assert_free_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl0_i.mode && !sel0_hit && !wr_en_i |=> cnt0_i == $past(inc0));

  assert_sync_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl0_i.mode && sel0_hit |=> cnt0_i == '0);

  assert_hold_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl0_i.mode && !ctl0_i.run |-> cnt0_i == '0);

  assert_trig_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl0_i.mode && sel0_hit |=> ctl0_i.run);

  assert_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_i && !ctl0_i.mode && !sel0_hit && !wr_en_i && lo_max |=> cnt1_i == $past(inc1));

  assert_cap_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i[0] |=> cap_vld_o[0] && (cap_data_o[CNT_W-1:0] == $past(cnt0_i)));

  assert_cap_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i[0] |=> !cap_vld_o[0]);

  assert_casc_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_i && cap_i[0] |=> cap_vld_o[1] && (cap_data_o[2*CNT_W-1:CNT_W] == $past(cnt1_i)));
endmodule

bind capt_timebase capt_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .src_i      (src_i),
  .cap_i      (cap_i),
  .cap_vld_o  (cap_vld_o),
  .cap_data_o (cap_data_o),
  .rd_data_o  (rd_data_o),
  .ctl0_i     (ctl_q[0]),
  .casc_i     (casc),
  .cnt0_i     (cnt_lo),
  .cnt1_i     (cnt_hi)
);

// File: tb/sim_capt_timebase.sv
module sim_capt_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_ch = 1'b0;
  logic [15:0]   wr_data = '0;
  logic          rd_ch = 1'b0;
  logic [15:0]   rd_data;
  logic [31:0]   src = '0;
  logic [1:0]    cap = '0;
  logic [1:0]    cap_vld;
  logic [2*W-1:0] cap_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capt_timebase #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_data_i(wr_data), .rd_ch_i(rd_ch), .rd_data_o(rd_data),
    .src_i(src), .cap_i(cap), .cap_vld_o(cap_vld), .cap_data_o(cap_data)
  );

  // reference model built from the requirements
  logic [4:0]   m_sel [2];
  logic         m_run [2], m_mode [2], m_casc [2];
  logic [W-1:0] m_cnt [2], m_cap [2];
  logic [1:0]   m_vld;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic c, lo_wrap;
    logic hit [2], clr [2], hold [2];
    logic [4:0] n_sel [2];
    logic n_run [2], n_mode [2], n_casc [2];
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_sel[i] = 5'd13; m_run[i] = 0; m_mode[i] = 0; m_casc[i] = 0;
        m_cnt[i] = '0; m_cap[i] = '0;
      end
      m_vld = '0;
    end else begin
      c = m_casc[0] & m_casc[1];
      if (c) begin
        m_vld = {cap[0], cap[0]};
        if (cap[0]) begin m_cap[0] = m_cnt[0]; m_cap[1] = m_cnt[1]; end
      end else begin
        m_vld = cap;
        for (int i = 0; i < 2; i++) if (cap[i]) m_cap[i] = m_cnt[i];
      end
      for (int i = 0; i < 2; i++) begin
        hit[i] = src[m_sel[i]];
        clr[i] = !m_mode[i] && hit[i];
        n_sel[i] = m_sel[i]; n_run[i] = m_run[i]; n_mode[i] = m_mode[i]; n_casc[i] = m_casc[i];
        if (wr_en && (wr_ch == i[0])) begin
          n_sel[i] = wr_data[4:0]; n_run[i] = wr_data[5];
          n_mode[i] = wr_data[7]; n_casc[i] = wr_data[8];
        end
        if (m_mode[i] && hit[i]) n_run[i] = 1'b1;
        hold[i] = n_mode[i] && !n_run[i];
      end
      lo_wrap = !(clr[0] || hold[0]) && (m_cnt[0] == '1);
      if (c) begin
        if (clr[0] || hold[0]) m_cnt[1] = '0;
        else if (lo_wrap) m_cnt[1] = m_cnt[1] + 1'b1;
      end else begin
        if (clr[1] || hold[1]) m_cnt[1] = '0;
        else m_cnt[1] = m_cnt[1] + 1'b1;
      end
      if (clr[0] || hold[0]) m_cnt[0] = '0;
      else m_cnt[0] = m_cnt[0] + 1'b1;
      for (int i = 0; i < 2; i++) begin
        m_sel[i] = n_sel[i]; m_run[i] = n_run[i]; m_mode[i] = n_mode[i]; m_casc[i] = n_casc[i];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic ch, input logic [15:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int s);
    src[s] = 1'b1;
    step();
    src = '0;
  endtask

  task automatic read_chk(input logic ch, input logic [15:0] exp, input string req);
    rd_ch = ch;
    #1;
    check(rd_data == exp, req, "control readback", {16'h0, rd_data}, {16'h0, exp});
  endtask

  // capture on one channel; compare with exp, or with the model when use_mdl
  task automatic cap_chk(input int ch, input string req, input bit use_mdl,
                         input logic [W-1:0] exp);
    logic [W-1:0] e, a;
    cap[ch] = 1'b1;
    step();
    cap = '0;
    e = use_mdl ? m_cap[ch] : exp;
    a = cap_data[ch*W +: W];
    check(cap_vld[ch], req, "capture strobe", 32'(cap_vld), 32'(1 << ch));
    check(a == e, req, "captured value", 32'(a), 32'(e));
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state, R11 read per channel
    read_chk(1'b0, 16'h000D, "R1");
    read_chk(1'b1, 16'h000D, "R11");
    check(cap_vld == 2'b00, "R1", "no strobe after reset", 32'(cap_vld), 0);

    // R2 layout and reserved bits
    wr(1'b1, 16'hFFFF);
    read_chk(1'b1, 16'h01BF, "R2");
    wr(1'b1, 16'h0000);
    read_chk(1'b1, 16'h0000, "R2");

    // R3 free run across wraps, consecutive captures
    wr(1'b0, 16'h0003);
    pulse(3);
    for (int i = 0; i < 300; i++) begin
      cap[0] = 1'b1;
      step();
      check(cap_vld[0] && (cap_data[W-1:0] == i[W-1:0]), "R3", "free-run value",
            32'(cap_data[W-1:0]), 32'(i[W-1:0]));
    end
    cap = '0;
    step();
    check(cap_vld[0] == 1'b0, "R9", "strobe drops", 32'(cap_vld), 0);

    // R4 selector sweep: neighbour ignored, selected source clears
    for (int s = 0; s < 32; s++) begin
      wr(1'b0, 16'(s));
      repeat (3) step();
      pulse((s + 1) % 32);
      cap_chk(0, "R4", 1'b1, '0);
      check(cap_data[W-1:0] != '0, "R4", "unselected source ignored", 32'(cap_data[W-1:0]), 1);
      pulse(s);
      cap_chk(0, "R4", 1'b0, '0);
    end

    // R9 capture coincident with sync clear keeps the old value
    wr(1'b0, 16'h0003);
    repeat (20) step();
    src[3] = 1'b1; cap[0] = 1'b1;
    step();
    src = '0; cap = '0;
    check(cap_vld[0] && (cap_data[W-1:0] == m_cap[0]) && (m_cap[0] != '0), "R9",
          "pre-clear value", 32'(cap_data[W-1:0]), 32'(m_cap[0]));
    cap_chk(0, "R9", 1'b0, '0);

    // R5 triggered mode holds at zero
    wr(1'b0, 16'h0085);
    repeat (4) step();
    cap_chk(0, "R5", 1'b0, '0);
    pulse(6);
    pulse(13);
    cap_chk(0, "R5", 1'b0, '0);
    read_chk(1'b0, 16'h0085, "R5");

    // R6 trigger starts, retrigger does not restart
    pulse(5);
    read_chk(1'b0, 16'h00A5, "R6");
    cap_chk(0, "R6", 1'b0, 8'd1);
    cap_chk(0, "R6", 1'b0, 8'd2);
    pulse(5);
    cap_chk(0, "R6", 1'b0, 8'd4);

    // R7 software stop/start, hardware set beats software clear
    wr(1'b0, 16'h0085);
    cap_chk(0, "R7", 1'b0, '0);
    wr(1'b0, 16'h00A5);
    cap_chk(0, "R7", 1'b0, 8'd1);
    wr_en = 1'b1; wr_ch = 1'b0; wr_data = 16'h0085; src[5] = 1'b1;
    step();
    wr_en = 1'b0; src = '0;
    read_chk(1'b0, 16'h00A5, "R7");
    cap_chk(0, "R7", 1'b1, '0);

    // R8/R10 cascade: 16-bit count through carries
    wr(1'b0, 16'h0100);
    wr(1'b1, 16'h0107);
    pulse(0);
    for (int i = 0; i < 600; i++) begin
      cap[0] = 1'b1;
      step();
      check((cap_vld == 2'b11) && (cap_data == 16'(i)), "R8", "cascade value",
            32'(cap_data), 32'(i));
    end
    cap = '0;
    step();
    check(cap_vld == 2'b00, "R10", "strobes drop", 32'(cap_vld), 0);
    pulse(7);
    cap[0] = 1'b1;
    step();
    cap = '0;
    check((cap_data == {m_cap[1], m_cap[0]}) && (cap_data != '0), "R8",
          "high selector ignored", 32'(cap_data), 32'({m_cap[1], m_cap[0]}));
    cap[1] = 1'b1;
    step();
    cap = '0;
    check(cap_vld == 2'b00, "R10", "capture 1 ignored", 32'(cap_vld), 0);
    wr(1'b0, 16'h0180);
    repeat (2) step();
    cap[0] = 1'b1;
    step();
    cap = '0;
    check(cap_data == '0, "R8", "pair held", 32'(cap_data), 0);
    pulse(0);
    cap[0] = 1'b1;
    step();
    cap = '0;
    check(cap_data == 16'd1, "R8", "pair triggered", 32'(cap_data), 1);

    // R4/R8 independent channels again
    wr(1'b0, 16'h0003);
    wr(1'b1, 16'h0009);
    repeat (10) step();
    pulse(9);
    cap_chk(1, "R4", 1'b0, '0);
    cap_chk(0, "R8", 1'b1, '0);
    check(cap_data[W-1:0] != '0, "R8", "low not cleared by high source",
          32'(cap_data[W-1:0]), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule